// File: doc/BRIEF.md
# Multiplexed Bus Cycle Strobe Sequencer

This block steps a multiplexed address/data bus cycle through the states T1, T2, T3, any number of wait states TW, and T4. It drives the control strobes an external address latch and data transceiver need: an address-latch pulse, a write strobe, an interrupt-acknowledge strobe, a transceiver enable, a transceiver direction and a memory-versus-I/O select. The core requests a cycle of one of three kinds, together with a space bit. A ready input stretches the cycle with wait states. A hold request makes the block release its floatable outputs.

Each bus state takes two clocks of `clk`. The first clock is the high half and the second is the low half. This lets strobes start or stop in the middle of a state while the logic uses a single clock edge. Each floatable output is a value pin plus an enable pin. While the enable is low, the value pin is forced high, so a weak pull-up gives the same level. The latch pulse and the acknowledge strobe are always driven.

Top module: `bus_strobe_gen`

## Requirements
- R1: `ale` is high only in the low half of T1 (`half`=1). It lasts exactly one clock, and T2 follows it.
- R2: `req_kind` is encoded as 00 read, 01 write, 10 interrupt acknowledge, and 11 is treated as read. `wr_n` is low in both halves of T2, T3 and every TW of a write cycle, and high at all other times.
- R3: `inta_n` is low in both halves of T2, T3 and every TW of an acknowledge cycle, and high at all other times. It is never low while `wr_n` is low.
- R4: In read and acknowledge cycles, `den_n` is low from the low half of T2 through the high half of T4.
- R5: In write cycles, `den_n` is low from the high half of T2 through the high half of T4.
- R6: `mio` is 1 for memory and 0 for I/O. `dtr` is 1 for write and 0 otherwise. Both take the new value when T1 is entered from idle. On a back-to-back cycle they take it at the start of the preceding T4, and they hold it through the cycle's own T4.
- R7: `ready` is sampled at the end of the low half of T3 and of each TW. A low sample inserts another TW. Throughout TW the strobe levels equal those of T3. `tstate` encodes idle 0, T1 1, T2 2, T3 3, TW 4, T4 5 and hold 6.
- R8: If a request is pending when `ready` is sampled high, the next cycle starts in T1 right after T4. Otherwise the block goes idle after T4. In idle `ale` is low and `wr_n`, `inta_n` and `den_n` are high.
- R9: `hold_req` is honoured in idle, or at the end of a T4 with no queued cycle, and it beats a pending request. In hold, `hold_ack` is 1 and all four enables are 0. `mio`, `wr_n`, `dtr` and `den_n` read 1, `ale` stays low and `inta_n` stays driven high.
- R10: `req_ack` is high, for the clock in which a request is taken, in idle or at the end of a ready T3/TW, when `req_valid` is high and `hold_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per bus state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request pending |
| req_kind | input | 2 | Cycle kind: 00 read, 01 write, 10 acknowledge |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| ready | input | 1 | Low inserts wait states |
| hold_req | input | 1 | Request to release the bus |
| req_ack | output | 1 | Request taken this clock |
| hold_ack | output | 1 | Bus released |
| tstate | output | 3 | Current bus state code |
| half | output | 1 | 0 high half, 1 low half of the state |
| ale | output | 1 | Address latch pulse |
| inta_n | output | 1 | Acknowledge strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wr_oe | output | 1 | Enable for wr_n |
| den_n | output | 1 | Transceiver enable, active low |
| den_oe | output | 1 | Enable for den_n |
| dtr | output | 1 | Transceiver direction, 1 transmit |
| dtr_oe | output | 1 | Enable for dtr |
| mio | output | 1 | Space select, 1 memory |
| mio_oe | output | 1 | Enable for mio |

## Verification
Every cycle kind, including the spare code 11, is run in both spaces with zero, one and two wait states. Each clock of each run is compared against a timeline computed from the half-state position. This separates a strobe edge that is off by one half from one that is off by a whole state, and it shows whether a wait state copies T3 or T4. Back-to-back pairs show whether the select and direction change at the start of T4 while the old cycle's enable is still low. Hold is tested both against a pending request in idle and when raised in the middle of a cycle. Together these show whether hold has priority and whether the running cycle finishes before the bus is released.

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_kind,
  input  logic       req_mem,
  input  logic       ready,
  input  logic       hold_req,
  output logic       req_ack,
  output logic       hold_ack,
  output logic [2:0] tstate,
  output logic       half,
  output logic       ale,
  output logic       inta_n,
  output logic       wr_n,
  output logic       wr_oe,
  output logic       den_n,
  output logic       den_oe,
  output logic       dtr,
  output logic       dtr_oe,
  output logic       mio,
  output logic       mio_oe
);
  localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2, S_T3 = 3'd3,
                         S_TW = 3'd4, S_T4 = 3'd5, S_HOLD = 3'd6;
  localparam logic [1:0] K_WR = 2'b01, K_IA = 2'b10;

  logic [2:0] st;
  logic       ph, pend, mio_r, dtr_r;
  logic [1:0] cur_kind, nxt_kind;

  wire grant   = req_valid && !hold_req;
  wire end_rdy = ph && (st == S_T3 || st == S_TW);
  wire is_wr   = cur_kind == K_WR;
  wire is_ia   = cur_kind == K_IA;
  wire mid     = st == S_T2 || st == S_T3 || st == S_TW;
  wire den_act = (mid && (is_wr || st != S_T2 || ph)) || (st == S_T4 && !ph);

  assign req_ack  = grant && (st == S_IDLE || (end_rdy && ready));
  assign hold_ack = st == S_HOLD;
  assign tstate   = st;
  assign half     = ph;
  assign ale      = st == S_T1 && ph;
  assign wr_n     = !(is_wr && mid);
  assign inta_n   = !(is_ia && mid);
  assign den_n    = hold_ack || !den_act;
  assign mio      = mio_r || hold_ack;
  assign dtr      = dtr_r || hold_ack;
  assign wr_oe    = !hold_ack;
  assign den_oe   = !hold_ack;
  assign dtr_oe   = !hold_ack;
  assign mio_oe   = !hold_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      pend     <= 1'b0;
      cur_kind <= 2'b00;
      nxt_kind <= 2'b00;
      mio_r    <= 1'b1;
      dtr_r    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          ph <= 1'b0;
          if (hold_req) st <= S_HOLD;
          else if (req_valid) begin
            st       <= S_T1;
            cur_kind <= req_kind;
            mio_r    <= req_mem;
            dtr_r    <= req_kind == K_WR;
          end
        end
        S_HOLD: if (!hold_req) st <= S_IDLE;
        S_T1, S_T2: begin
          ph <= !ph;
          if (ph) st <= st + 3'd1;
        end
        S_T3, S_TW: begin
          ph <= !ph;
          if (ph) begin
            if (ready) begin
              st <= S_T4;
              if (grant) begin
                pend     <= 1'b1;
                nxt_kind <= req_kind;
                mio_r    <= req_mem;
                dtr_r    <= req_kind == K_WR;
              end
            end else st <= S_TW;
          end
        end
        S_T4: begin
          ph <= !ph;
          if (ph) begin
            if (pend) begin
              st       <= S_T1;
              cur_kind <= nxt_kind;
              pend     <= 1'b0;
            end else if (hold_req) st <= S_HOLD;
            else st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_ale_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && tstate == S_T2));
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !inta_n));
  p_den_covers_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !den_n);
  p_wait_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == S_TW) |-> $stable({wr_n, inta_n, den_n, mio, dtr}));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate == S_IDLE) |-> (wr_n && inta_n && den_n && !ale));
  p_hold_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!mio_oe && !wr_oe && !dtr_oe && !den_oe && mio && wr_n
                  && dtr && den_n && inta_n && !ale && !req_ack));
endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_mem = 1'b0, ready = 1'b1, hold_req = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic req_ack, hold_ack, half, ale, inta_n, wr_n, wr_oe, den_n, den_oe;
  logic dtr, dtr_oe, mio, mio_oe;
  logic [2:0] tstate;
  int checks = 0, errors = 0;

  always #5 clk = !clk;

  bus_strobe_gen dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " R8 tstate"}, tstate, 0);
    chk({tag, " R8 quiet"}, {ale, wr_n, inta_n, den_n}, 4'b0111);
  endtask

  task automatic chk_hold(input string tag);
    chk({tag, " R9 state"}, {tstate, hold_ack}, {3'd6, 1'b1});
    chk({tag, " R9 enables"}, {mio_oe, wr_oe, dtr_oe, den_oe}, 0);
    chk({tag, " R9 levels"}, {mio, wr_n, dtr, den_n, inta_n, ale}, 6'b111110);
  endtask

  task automatic run_cycle(input bit issue, input int k, input int m, input int n,
                           input bit nxt, input int nk, input int nm, input int hold_at);
    int last = 7 + 2 * n;
    if (issue) begin
      req_valid = 1'b1; req_kind = 2'(k); req_mem = 1'(m);
      #1 chk("R10 ack idle", req_ack, 1);
      @(negedge clk);
    end
    for (int idx = 0; idx <= last; idx++) begin
      int es = idx < 2 ? 1 : idx < 4 ? 2 : idx < 6 ? 3 : idx < 6 + 2 * n ? 4 : 5;
      bit strb = idx >= 2 && idx <= 5 + 2 * n;
      bit dlow = (k == 1 ? idx >= 2 : idx >= 3) && idx <= 6 + 2 * n;
      bit new_sel = nxt && idx >= 6 + 2 * n;
      if (idx == 0) begin
        req_valid = nxt; req_kind = 2'(nk); req_mem = 1'(nm);
      end
      if (idx == hold_at) hold_req = 1'b1;
      chk("R7 tstate", {tstate, half}, {es[2:0], idx[0]});
      chk("R1 ale", ale, idx == 1);
      chk("R2 wr_n", wr_n, !(k == 1 && strb));
      chk("R3 inta_n", inta_n, !(k == 2 && strb));
      chk(k == 1 ? "R5 den_n" : "R4 den_n", den_n, !dlow);
      chk("R6 mio", mio, new_sel ? nm : m);
      chk("R6 dtr", dtr, new_sel ? (nk == 1) : (k == 1));
      ready = !(idx >= 5 && idx[0] && idx < 5 + 2 * n);
      if (idx == 5 + 2 * n) #1 chk("R10 ack T3", req_ack, nxt);
      if (idx == 6 + 2 * n) req_valid = 1'b0;
      @(negedge clk);
    end
    ready = 1'b1;
    if (!nxt) begin
      if (hold_req) chk_hold("after cycle");
      else chk_idle("after cycle");
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R8 state", tstate, 0);
    chk("reset R8 strobes", {ale, wr_n, inta_n, den_n}, 4'b0111);
    chk("reset R9 enables", {hold_ack, mio_oe, wr_oe, dtr_oe, den_oe}, 5'b01111);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("post reset");

    for (int k = 0; k < 4; k++)
      for (int m = 0; m < 2; m++)
        for (int n = 0; n < 3; n++)
          run_cycle(1, k, m, n, 0, 0, 0, -1);

    // R8 back-to-back: write then read, and acknowledge then write
    run_cycle(1, 1, 1, 0, 1, 0, 0, -1);
    run_cycle(0, 0, 0, 1, 0, 0, 0, -1);
    run_cycle(1, 2, 0, 2, 1, 1, 1, -1);
    run_cycle(0, 1, 1, 0, 0, 0, 0, -1);

    // R9 hold beats a pending request in idle
    hold_req = 1'b1; req_valid = 1'b1; req_kind = 2'b10; req_mem = 1'b0;
    #1 chk("R9 hold priority ack", req_ack, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_hold("idle hold");
    end
    hold_req = 1'b0;
    @(negedge clk);
    chk("R9 leave hold", tstate, 0);
    #1 chk("R10 ack after hold", req_ack, 1);
    @(negedge clk);
    run_cycle(0, 2, 0, 1, 0, 0, 0, -1);

    // R9 hold raised mid-cycle: cycle completes, then bus released
    run_cycle(1, 1, 0, 1, 0, 0, 0, 3);
    hold_req = 1'b0;
    @(negedge clk);
    chk_idle("hold released");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule